// File: doc/BRIEF.md
# Single-Wire Bus Time-Slot Master

This block is the host-side timing engine for an open-drain single-wire data line. A caller asks for one time slot at a time: write a 0, write a 1, or read a bit. The engine pulls the line low at the start of the slot. It then releases the line, or keeps holding it, on a schedule measured in microsecond ticks. A single-cycle tick input supplies those ticks, and the surrounding logic derives it from the system clock. After every slot the engine leaves the line released for a recovery gap and only then accepts a new request.

For a read slot the engine passes the line through a two-flop synchronizer. It captures the bit at a fixed point that lies inside the window in which a slave's answer is still valid. When the recovery gap ends, the engine returns the captured bit together with a one-cycle completion pulse. Reset and presence signalling, byte assembly and command sequencing belong to the caller.

Top module: `sws_slot_master`

## Requirements
- R1: After reset `busy`, `pull_low` and `done` are 0 and `rd_bit` is 1.
- R2: `req_kind` encodes 2'b00 as write-0, 2'b01 as write-1 and 2'b10 as read. A request with 2'b11 is ignored and starts no slot.
- R3: A request is accepted on a rising clock edge where `req_valid` is 1 and `busy` is 0. `pull_low` and `busy` rise in the next cycle. A request made while `busy` is 1 is ignored.
- R4: A write-0 slot holds `pull_low` for T_SLOT ticks (default 65).
- R5: A write-1 slot holds `pull_low` for T_W1_LOW ticks (default 6), so the line is high at tick 30 of the slot.
- R6: A read slot holds `pull_low` for T_RD_LOW ticks (default 2).
- R7: A read slot captures the synchronized line on the tick that ends microsecond T_SAMPLE (default 12). The captured level is returned on `rd_bit`, where 0 means the slave held the line low.
- R8: `busy` stays high for T_SLOT + T_REC ticks (default 67). It falls in the same cycle as a `done` pulse that lasts exactly one cycle.
- R9: Write slots leave `rd_bit` unchanged.
- R10: If a request is held high across the end of a slot, it is accepted in the `done` cycle. The line then stays released for exactly T_REC ticks (default 2) between the two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| req_valid | input | 1 | Slot request |
| req_kind | input | 2 | Slot type: 00 write-0, 01 write-1, 10 read, 11 ignored |
| line_in | input | 1 | Raw level of the data line |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| busy | output | 1 | High from the first cycle of a slot to the end of recovery |
| done | output | 1 | One-cycle pulse at the end of recovery |
| rd_bit | output | 1 | Bit captured by the last read slot |

## Verification
The assertions take it for granted that `us_tick` is a single-cycle pulse with several idle clocks between pulses, so the synchronizer delay always ends before the next tick. They also take it for granted that `req_kind` is stable in the cycle in which `req_valid` is sampled. The bench generates the tick every four clocks and changes requests only on falling edges. Its slave model changes the line only on falling edges and releases it before each slot starts.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [1:0] {
    SK_WR0  = 2'b00,
    SK_WR1  = 2'b01,
    SK_READ = 2'b10,
    SK_RSVD = 2'b11
  } slot_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_SLOT = 2'b01,
    PH_REC  = 2'b10
  } phase_e;

  // Number of microseconds the line is held low for a given slot kind.
  function automatic int unsigned low_us(slot_kind_e k, int unsigned t_slot,
                                         int unsigned t_w1, int unsigned t_rd);
    case (k)
      SK_WR0:  return t_slot;
      SK_WR1:  return t_w1;
      default: return t_rd;
    endcase
  endfunction

  // Total microseconds from the first pulled cycle to the end of recovery.
  function automatic int unsigned busy_us(int unsigned t_slot, int unsigned t_rec);
    return t_slot + t_rec;
  endfunction

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sws_us_timer.sv
module sws_us_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // The count moves only on a tick or a clear (R8 timing basis)
  assert_cnt_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ($past(inc) || $past(clr)));
endmodule

// File: rtl/sws_slot_fsm.sv
module sws_slot_fsm
  import sws_pkg::*;
#(
  parameter int T_SLOT   = 65,
  parameter int T_REC    = 2,
  parameter int T_W1_LOW = 6,
  parameter int T_RD_LOW = 2,
  parameter int T_SAMPLE = 12,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             line_s,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             pull_low,
  output logic             busy,
  output logic             done,
  output logic             rd_bit
);
  localparam logic [CNT_W-1:0] SLOT_LAST   = CNT_W'(T_SLOT - 1);
  localparam logic [CNT_W-1:0] REC_LAST    = CNT_W'(T_REC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(T_SAMPLE - 1);

  phase_e           phase_q;
  slot_kind_e       kind_q;
  logic [CNT_W-1:0] low_len_q;
  logic             done_q;
  logic             rd_q;

  // Named internal events
  slot_kind_e req_k;
  logic       accept_ev;
  logic       slot_tick;
  logic       slot_end_ev;
  logic       sample_ev;
  logic       rec_end_ev;

  assign req_k       = slot_kind_e'(req_kind);
  assign accept_ev   = (phase_q == PH_IDLE) && req_valid && (req_k != SK_RSVD);
  assign slot_tick   = (phase_q == PH_SLOT) && us_tick;
  assign slot_end_ev = slot_tick && (cnt == SLOT_LAST);
  assign sample_ev   = slot_tick && (cnt == SAMPLE_LAST) && (kind_q == SK_READ);
  assign rec_end_ev  = (phase_q == PH_REC) && us_tick && (cnt == REC_LAST);

  assign cnt_clr = accept_ev || slot_end_ev;
  assign cnt_inc = us_tick && (phase_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= SK_WR0;
      low_len_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept_ev) begin
          phase_q   <= PH_SLOT;
          kind_q    <= req_k;
          low_len_q <= CNT_W'(low_us(req_k, T_SLOT, T_W1_LOW, T_RD_LOW));
        end
        PH_SLOT: if (slot_end_ev) phase_q <= PH_REC;
        PH_REC:  if (rec_end_ev)  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= 1'b1;
    end else begin
      done_q <= rec_end_ev;
      if (sample_ev) rd_q <= line_s;
    end
  end

  assign pull_low = (phase_q == PH_SLOT) && (cnt < low_len_q);
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign rd_bit   = rd_q;

  // The line is pulled only inside a slot
  assert_pull_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy);
  // A slot starts only after a valid, non-reserved request while idle
  assert_start_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && ($past(req_kind) != 2'b11)));
  // Every slot begins with the line pulled low
  assert_start_pulls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pull_low);
  // The completion pulse lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // Busy ends only together with done
  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // The slot counter never runs past the slot length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLOT) |-> (cnt < CNT_W'(T_SLOT)));
  // The read bit changes only inside a read slot
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> ($past(phase_q) == PH_SLOT && $past(kind_q) == SK_READ));
endmodule

// File: rtl/sws_slot_master.sv
module sws_slot_master #(
  parameter int T_SLOT    = 65,
  parameter int T_REC     = 2,
  parameter int T_W1_LOW  = 6,
  parameter int T_RD_LOW  = 2,
  parameter int T_SAMPLE  = 12,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       line_in,
  output logic       pull_low,
  output logic       busy,
  output logic       done,
  output logic       rd_bit
);
  localparam int CNT_W = $clog2(T_SLOT + 1);

  logic             line_s;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_inc;

  sws_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  sws_us_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  sws_slot_fsm #(
    .T_SLOT(T_SLOT), .T_REC(T_REC), .T_W1_LOW(T_W1_LOW),
    .T_RD_LOW(T_RD_LOW), .T_SAMPLE(T_SAMPLE), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .req_valid(req_valid), .req_kind(req_kind), .line_s(line_s),
    .cnt(cnt), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .pull_low(pull_low), .busy(busy), .done(done), .rd_bit(rd_bit)
  );
endmodule

// File: tb/sws_slot_master_bench.sv
`timescale 1ns/1ps
module sws_slot_master_bench;
  localparam int SLOT_US = 65;
  localparam int REC_US  = 2;
  localparam int W1_US   = 6;
  localparam int RD_US   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       slave_low = 1'b0;
  logic       line_in;
  logic       pull_low, busy, done, rd_bit;
  logic [1:0] div = 2'd0;

  int checks = 0;
  int fails  = 0;
  logic model_rd = 1'b1;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      div <= 2'd0;
      us_tick <= 1'b0;
    end else begin
      div <= div + 2'd1;
      us_tick <= (div == 2'd3);
    end
  end

  assign line_in = ~(pull_low | slave_low);

  sws_slot_master u_sws_slot_master (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .req_valid(req_valid), .req_kind(req_kind), .line_in(line_in),
    .pull_low(pull_low), .busy(busy), .done(done), .rd_bit(rd_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input int k);
    if (k == 0) return SLOT_US;
    if (k == 1) return W1_US;
    return RD_US;
  endfunction

  // mode: 0 slave silent, 1 slave holds low for the first 15 us, 2 slave pulls late
  task automatic run_slot(input int k, input int mode, input int off, input bit inj);
    int lo = 0, bz = 0, since = 0, guard = 0;
    int exp_r;
    repeat (off) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(k);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pull_low === 1'b1 && busy === 1'b1, "R3", int'(pull_low), 1);
    while (!done && guard < 2000) begin
      guard++;
      if (req_valid) req_valid = 1'b0;
      if (us_tick) begin
        if (pull_low) lo++;
        if (busy) bz++;
        since++;
        if (since == 30 && k != 2)
          chk(line_in === (k == 1), (k == 1) ? "R5" : "R4", int'(line_in), int'(k == 1));
        if (inj && since == 20) begin
          req_valid = 1'b1;
          req_kind  = 2'b00;
        end
      end
      slave_low = (k == 2) && ((mode == 1 && since < 15) ||
                               (mode == 2 && since >= 14 && since < 20));
      @(negedge clk);
    end
    slave_low = 1'b0;
    req_valid = 1'b0;
    chk(lo == exp_low(k), (k == 0) ? "R4" : (k == 1) ? "R5" : "R6", lo, exp_low(k));
    chk(bz == SLOT_US + REC_US, "R8", bz, SLOT_US + REC_US);
    chk(done === 1'b1 && busy === 1'b0, "R8", int'(busy), 0);
    if (k == 2) model_rd = (mode == 1) ? 1'b0 : 1'b1;
    exp_r = int'(model_rd);
    chk(rd_bit === model_rd, (k == 2) ? "R7" : "R9", int'(rd_bit), exp_r);
    @(negedge clk);
    chk(done === 1'b0, "R8", int'(done), 0);
    if (inj) begin
      repeat (8) @(negedge clk);
      chk(busy === 1'b0 && pull_low === 1'b0, "R3", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rel;
    int k;
    int m;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && pull_low === 1'b0 && done === 1'b0 && rd_bit === 1'b1,
        "R1", int'({busy, pull_low, done, rd_bit}), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reserved kind ignored
    req_valid = 1'b1; req_kind = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy === 1'b0 && pull_low === 1'b0, "R2", int'(busy), 0);

    // Sweep: reads first (ending with rd_bit 0), then writes, over tick phases
    for (int i = 0; i < 3; i++) begin
      k = (i == 0) ? 2 : i - 1;
      for (int off = 0; off < 4; off++) begin
        for (int j = 0; j < 3; j++) begin
          if (k != 2 && j > 0) continue;
          m = (k != 2) ? 0 : (j == 0) ? 2 : (j == 1) ? 0 : 1;
          run_slot(k, m, off, 1'b0);
        end
      end
    end

    // R3: request during a write-1 slot is ignored
    run_slot(1, 0, 1, 1'b1);

    // R10: request held across slot end
    req_valid = 1'b1; req_kind = 2'b00;
    @(negedge clk);
    while (pull_low) @(negedge clk);
    while (!pull_low) @(negedge clk);
    while (pull_low) @(negedge clk);
    rel = 0;
    while (!pull_low) begin
      if (us_tick) rel++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rel == REC_US, "R10", rel, REC_US);
    chk(busy === 1'b1, "R10", int'(busy), 1);
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, "R10", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule